// File: doc/BRIEF.md
# Register Window Pointer Controller

This block keeps the current window pointer of a processor whose integer registers are organised as a ring of `NWIN` overlapping windows. A per-window invalid mask marks windows that may not be entered. Four single-cycle request strobes drive the block:

- save moves the pointer one window down,
- restore moves it one window up,
- trap return moves it up and also restores the privilege state,
- status write loads the pointer and the other status fields at once.

Every pointer move wraps around the ring. The target window is probed against the invalid mask before anything is committed.

When a request cannot complete, the block raises a one-cycle trap pulse with a two-bit cause code, and the pointer stays where it was. The block also holds the other status fields: the trap-enable bit, the supervisor and previous-supervisor bits, a 4-bit interrupt level, a floating-point enable bit and four condition-code bits. It returns all of them packed into one 32-bit status word. The register storage itself, trap vectoring and pipeline control are left to the surrounding core.

Top module: `winptr_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state is set as follows: pointer 0, trap-enable 0, supervisor 1, previous-supervisor 0, interrupt level 0, floating-point enable 0, condition codes 0, invalid mask all zero, no trap pending. The status word then reads `{VERSION, 24'h000080}`.
- R2: A save moves the pointer to pointer-1. From window 0 it wraps to window `NWIN-1`.
- R3: A restore moves the pointer to pointer+1. From window `NWIN-1` it wraps to window 0.
- R4: Bit i of the invalid mask guards window i. The mask is loaded from `mask_data` when `mask_we` is high and is used from the next cycle on.
  - A save whose target is masked raises cause 1 (overflow).
  - A restore whose target is masked raises cause 2 (underflow).
  - In both cases the pointer is left unchanged.
- R5: A trap return while trap-enable is 1 raises cause 3 (illegal) and changes no state.
- R6: A trap return while trap-enable is 0 always sets trap-enable to 1.
  - If window pointer+1 (with wrap) is masked, it raises cause 2 and leaves the pointer and supervisor bit unchanged.
  - Otherwise it moves the pointer there and copies previous-supervisor into supervisor.
- R7: A status write whose pointer field (bits 4:0) is `NWIN` or more raises cause 3 and changes no state.
- R8: A legal status write loads the fields from these bit positions:
  - pointer from bits 4:0,
  - trap-enable from bit 5,
  - previous-supervisor from bit 6,
  - supervisor from bit 7,
  - interrupt level from bits 11:8,
  - floating-point enable from bit 12,
  - condition codes from bits 23:20.
- R9: `sr_rdata` packs the state back into the R8 positions. It carries `VERSION` in bits 31:24 and zero in bits 19:13.
- R10: The result of a request appears at the outputs one clock edge after the strobe. `trap_valid` is high for exactly that one cycle, and `trap_cause` reads 0 whenever it is low. A cycle with no strobe raises no trap and leaves the pointer unchanged.
- R11: When several strobes are high together, only the highest-priority one acts and the others are ignored. The priority order is save, then restore, then trap return, then status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| save_req | input | 1 | Save request strobe |
| restore_req | input | 1 | Restore request strobe |
| rett_req | input | 1 | Trap-return request strobe |
| srw_req | input | 1 | Status-word write strobe |
| srw_data | input | 32 | Status word to write |
| mask_we | input | 1 | Invalid-mask load enable |
| mask_data | input | NWIN | New invalid mask, bit i guards window i |
| cwp | output | 5 | Current window pointer |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | 0 none, 1 overflow, 2 underflow, 3 illegal |
| traps_en | output | 1 | Trap-enable bit |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous-supervisor bit |
| pil | output | 4 | Interrupt level |
| sr_rdata | output | 32 | Packed status word |

## Verification
Every result is registered, so the pointer, the status bits, the trap pulse and the packed status word all change on the first rising edge after a strobe. A mask load is seen by the request that follows it one cycle later. The bench raises each strobe at a falling edge and drops it at the next falling edge. It samples the outputs at that same falling edge, which lies half a period after the single edge that carries the result. The one-cycle width of the trap pulse is confirmed by sampling again one full cycle later, with no strobe high.

// File: rtl/winptr_pkg.sv
// Package: shared encodings and status-word field positions for the
// window pointer controller. Assumes a 32-bit status word.
package winptr_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_OVF  = 2'd1,
        CAUSE_UNF  = 2'd2,
        CAUSE_ILL  = 2'd3
    } trap_cause_e;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_SAVE    = 3'd1,
        OP_RESTORE = 3'd2,
        OP_RETT    = 3'd3,
        OP_SRW     = 3'd4
    } win_op_e;

    localparam int SR_W        = 32;
    localparam int SR_CWP_W    = 5;
    localparam int SR_ET_BIT   = 5;
    localparam int SR_PS_BIT   = 6;
    localparam int SR_S_BIT    = 7;
    localparam int SR_PIL_LSB  = 8;
    localparam int SR_PIL_W    = 4;
    localparam int SR_EF_BIT   = 12;
    localparam int SR_ICC_LSB  = 20;
    localparam int SR_ICC_W    = 4;
    localparam int SR_VER_LSB  = 24;
    localparam int SR_VER_W    = 8;

endpackage

// File: rtl/winptr_opsel.sv
// Module: priority encoder turning the four request strobes into one
// operation. Assumes strobes may overlap; save wins, then restore, then
// trap return, then status write.
module winptr_opsel
    import winptr_pkg::*;
(
    input  logic    save_req,
    input  logic    restore_req,
    input  logic    rett_req,
    input  logic    srw_req,
    output win_op_e op
);

    // Pick the single operation that acts this cycle.
    always_comb begin
        if (save_req)         op = OP_SAVE;
        else if (restore_req) op = OP_RESTORE;
        else if (rett_req)    op = OP_RETT;
        else if (srw_req)     op = OP_SRW;
        else                  op = OP_IDLE;
    end

endmodule

// File: rtl/winptr_step.sv
// Module: neighbour windows of the current pointer with ring wrap-around.
// Assumes cur_idx is always below NWIN.
module winptr_step #(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic [CW-1:0] cur_idx,
    output logic [CW-1:0] down_idx,
    output logic [CW-1:0] up_idx
);

    localparam logic [CW-1:0] TOP_IDX = CW'(NWIN - 1);

    // Downward step wraps from window 0 to the top window.
    always_comb begin
        if (cur_idx == '0) down_idx = TOP_IDX;
        else               down_idx = cur_idx - 1'b1;
    end

    // Upward step wraps from the top window to window 0.
    always_comb begin
        if (cur_idx == TOP_IDX) up_idx = '0;
        else                    up_idx = cur_idx + 1'b1;
    end

endmodule

// File: rtl/winptr_maskprobe.sv
// Module: tests whether a window index is marked invalid. Built as a
// one-hot decode ANDed with the mask, then OR-reduced, so depth grows
// with log2(NWIN). Assumes idx below NWIN.
module winptr_maskprobe #(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  logic [NWIN-1:0] mask,
    input  logic [CW-1:0]   idx,
    output logic            hit
);

    logic [NWIN-1:0] sel;

    // One decode term per window.
    for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
        assign sel[gi] = mask[gi] & (idx == CW'(gi));
    end

    // Any guarded window selected means the target is invalid.
    assign hit = |sel;

endmodule

// File: rtl/winptr_ctrl.sv
// Module: register window pointer controller (top). Holds the window
// pointer, the invalid mask and the privilege/interrupt status fields,
// executes save, restore, trap return and status write requests, and
// reports failures as a one-cycle trap pulse. Assumes 2 <= NWIN <= 32,
// synchronous active-low reset, and that all outputs are registered.
module winptr_ctrl
    import winptr_pkg::*;
#(
    parameter int               NWIN    = 8,
    parameter logic [7:0]       VERSION = 8'h3C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                save_req,
    input  logic                restore_req,
    input  logic                rett_req,
    input  logic                srw_req,
    input  logic [31:0]         srw_data,
    input  logic                mask_we,
    input  logic [NWIN-1:0]     mask_data,
    output logic [4:0]          cwp,
    output logic                trap_valid,
    output logic [1:0]          trap_cause,
    output logic                traps_en,
    output logic                sup,
    output logic                prev_sup,
    output logic [3:0]          pil,
    output logic [31:0]         sr_rdata
);

    localparam int CW = $clog2(NWIN);
    localparam logic [SR_CWP_W:0] NWIN_EXT = (SR_CWP_W + 1)'(NWIN);

    // Architectural state.
    logic [CW-1:0]       cwp_q,  cwp_d;
    logic                et_q,   et_d;
    logic                s_q,    s_d;
    logic                ps_q,   ps_d;
    logic [SR_PIL_W-1:0] pil_q,  pil_d;
    logic                ef_q,   ef_d;
    logic [SR_ICC_W-1:0] icc_q,  icc_d;
    logic [NWIN-1:0]     mask_q;
    logic                tv_q,   tv_d;
    trap_cause_e         cause_q, cause_d;

    win_op_e             op;
    logic [CW-1:0]       down_idx, up_idx;
    logic                down_bad, up_bad;
    logic [SR_CWP_W:0]   srw_fld;
    logic                srw_ok;

    winptr_opsel u_opsel (
        .save_req    (save_req),
        .restore_req (restore_req),
        .rett_req    (rett_req),
        .srw_req     (srw_req),
        .op          (op)
    );

    winptr_step #(.NWIN(NWIN), .CW(CW)) u_step (
        .cur_idx  (cwp_q),
        .down_idx (down_idx),
        .up_idx   (up_idx)
    );

    winptr_maskprobe #(.NWIN(NWIN), .CW(CW)) u_probe_down (
        .mask (mask_q),
        .idx  (down_idx),
        .hit  (down_bad)
    );

    winptr_maskprobe #(.NWIN(NWIN), .CW(CW)) u_probe_up (
        .mask (mask_q),
        .idx  (up_idx),
        .hit  (up_bad)
    );

    // Range test of the pointer field carried by a status write.
    assign srw_fld = {1'b0, srw_data[SR_CWP_W-1:0]};
    assign srw_ok  = (srw_fld < NWIN_EXT);

    // Next-state selection for the operation chosen this cycle.
    always_comb begin
        cwp_d   = cwp_q;
        et_d    = et_q;
        s_d     = s_q;
        ps_d    = ps_q;
        pil_d   = pil_q;
        ef_d    = ef_q;
        icc_d   = icc_q;
        tv_d    = 1'b0;
        cause_d = CAUSE_NONE;
        case (op)
            OP_SAVE: begin
                if (down_bad) begin
                    tv_d    = 1'b1;
                    cause_d = CAUSE_OVF;
                end else begin
                    cwp_d = down_idx;
                end
            end
            OP_RESTORE: begin
                if (up_bad) begin
                    tv_d    = 1'b1;
                    cause_d = CAUSE_UNF;
                end else begin
                    cwp_d = up_idx;
                end
            end
            OP_RETT: begin
                if (et_q) begin
                    tv_d    = 1'b1;
                    cause_d = CAUSE_ILL;
                end else begin
                    et_d = 1'b1;
                    if (up_bad) begin
                        tv_d    = 1'b1;
                        cause_d = CAUSE_UNF;
                    end else begin
                        cwp_d = up_idx;
                        s_d   = ps_q;
                    end
                end
            end
            OP_SRW: begin
                if (!srw_ok) begin
                    tv_d    = 1'b1;
                    cause_d = CAUSE_ILL;
                end else begin
                    cwp_d = srw_data[CW-1:0];
                    et_d  = srw_data[SR_ET_BIT];
                    ps_d  = srw_data[SR_PS_BIT];
                    s_d   = srw_data[SR_S_BIT];
                    pil_d = srw_data[SR_PIL_LSB +: SR_PIL_W];
                    ef_d  = srw_data[SR_EF_BIT];
                    icc_d = srw_data[SR_ICC_LSB +: SR_ICC_W];
                end
            end
            default: begin
                cwp_d = cwp_q;
            end
        endcase
    end

    // Status and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q   <= '0;
            et_q    <= 1'b0;
            s_q     <= 1'b1;
            ps_q    <= 1'b0;
            pil_q   <= '0;
            ef_q    <= 1'b0;
            icc_q   <= '0;
            tv_q    <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            cwp_q   <= cwp_d;
            et_q    <= et_d;
            s_q     <= s_d;
            ps_q    <= ps_d;
            pil_q   <= pil_d;
            ef_q    <= ef_d;
            icc_q   <= icc_d;
            tv_q    <= tv_d;
            cause_q <= cause_d;
        end
    end

    // Invalid-window mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    // Packed status word readback.
    always_comb begin
        sr_rdata                                 = '0;
        sr_rdata[SR_CWP_W-1:0]                   = SR_CWP_W'(cwp_q);
        sr_rdata[SR_ET_BIT]                      = et_q;
        sr_rdata[SR_PS_BIT]                      = ps_q;
        sr_rdata[SR_S_BIT]                       = s_q;
        sr_rdata[SR_PIL_LSB +: SR_PIL_W]         = pil_q;
        sr_rdata[SR_EF_BIT]                      = ef_q;
        sr_rdata[SR_ICC_LSB +: SR_ICC_W]         = icc_q;
        sr_rdata[SR_VER_LSB +: SR_VER_W]         = VERSION;
    end

    // Output drive from state.
    assign cwp        = SR_CWP_W'(cwp_q);
    assign trap_valid = tv_q;
    assign trap_cause = cause_q;
    assign traps_en   = et_q;
    assign sup        = s_q;
    assign prev_sup   = ps_q;
    assign pil        = pil_q;

endmodule

// File: rtl/winptr_ctrl_chk.sv
// Module: property checker for winptr_ctrl, bound to every instance.
// Assumes the top's registered-output timing (results one edge after
// the strobe).
module winptr_ctrl_chk #(
    parameter int NWIN = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            save_req,
    input logic            restore_req,
    input logic            rett_req,
    input logic            srw_req,
    input logic [31:0]     srw_data,
    input logic [NWIN-1:0] mask_q,
    input logic [4:0]      cwp,
    input logic            trap_valid,
    input logic [1:0]      trap_cause,
    input logic            traps_en,
    input logic [3:0]      pil
);

    logic [5:0] ring_below;
    logic       any_req;

    // Window below the pointer, computed by modulo arithmetic.
    assign ring_below = 6'((32'(cwp) + 32'(NWIN) - 1) % 32'(NWIN));
    assign any_req    = save_req | restore_req | rett_req | srw_req;

    // R2 R3: pointer never leaves the ring.
    p_cwp_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cwp) < NWIN);

    // R4: a masked save target yields an overflow pulse.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && mask_q[ring_below[4:0]]) |=> (trap_valid && trap_cause == 2'd1));

    // R4 R7: any trap leaves the pointer where it was.
    p_trap_keeps_cwp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (cwp == $past(cwp)));

    // R5: trap return with traps enabled is illegal.
    p_rett_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rett_req && !save_req && !restore_req && traps_en)
        |=> (trap_valid && trap_cause == 2'd3 && traps_en));

    // R6: trap return with traps disabled always enables them.
    p_rett_sets_et_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rett_req && !save_req && !restore_req && !traps_en) |=> traps_en);

    // R7: out-of-range status write is illegal and keeps the level.
    p_srw_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (srw_req && !save_req && !restore_req && !rett_req && 32'(srw_data[4:0]) >= NWIN)
        |=> (trap_valid && trap_cause == 2'd3 && $stable(pil)));

    // R10: cause is zero exactly when no trap is flagged.
    p_cause_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |-> (trap_cause == 2'd0));

    // R10: a quiet cycle raises nothing and holds the pointer.
    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!trap_valid && $stable(cwp)));

endmodule

bind winptr_ctrl winptr_ctrl_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .save_req    (save_req),
    .restore_req (restore_req),
    .rett_req    (rett_req),
    .srw_req     (srw_req),
    .srw_data    (srw_data),
    .mask_q      (mask_q),
    .cwp         (cwp),
    .trap_valid  (trap_valid),
    .trap_cause  (trap_cause),
    .traps_en    (traps_en),
    .pil         (pil)
);

// File: tb/winptr_ctrl_bench.sv
// Bench for winptr_ctrl with NWIN = 8 and VERSION = 8'h3C.
module winptr_ctrl_bench;

    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        save_req = 1'b0, restore_req = 1'b0, rett_req = 1'b0, srw_req = 1'b0;
    logic [31:0] srw_data = '0;
    logic        mask_we = 1'b0;
    logic [NW-1:0] mask_data = '0;
    logic [4:0]  cwp;
    logic        trap_valid;
    logic [1:0]  trap_cause;
    logic        traps_en, sup, prev_sup;
    logic [3:0]  pil;
    logic [31:0] sr_rdata;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    winptr_ctrl #(.NWIN(NW), .VERSION(8'h3C)) u_winptr_ctrl (
        .clk(clk), .rst_n(rst_n),
        .save_req(save_req), .restore_req(restore_req),
        .rett_req(rett_req), .srw_req(srw_req), .srw_data(srw_data),
        .mask_we(mask_we), .mask_data(mask_data),
        .cwp(cwp), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .traps_en(traps_en), .sup(sup), .prev_sup(prev_sup), .pil(pil),
        .sr_rdata(sr_rdata)
    );

    // Vector: op[41:39] data[38:7] exp_cwp[6:2] exp_cause[1:0]
    // op: 0 idle, 1 save, 2 restore, 3 trap return, 4 status write, 5 mask load
    localparam logic [41:0] VEC [13] = '{
        {3'd1, 32'h0000_0000, 5'd7, 2'd0},   // R2 wrap 0 -> 7
        {3'd1, 32'h0000_0000, 5'd6, 2'd0},   // R2
        {3'd2, 32'h0000_0000, 5'd7, 2'd0},   // R3
        {3'd2, 32'h0000_0000, 5'd0, 2'd0},   // R3 wrap 7 -> 0
        {3'd5, 32'h0000_0002, 5'd0, 2'd0},   // mask window 1
        {3'd2, 32'h0000_0000, 5'd0, 2'd2},   // R4 underflow
        {3'd5, 32'h0000_0080, 5'd0, 2'd0},   // mask window 7
        {3'd1, 32'h0000_0000, 5'd0, 2'd1},   // R4 overflow
        {3'd4, 32'h0000_0008, 5'd0, 2'd3},   // R7 field 8 illegal
        {3'd4, 32'h00A0_1543, 5'd3, 2'd0},   // R8 legal write
        {3'd3, 32'h0000_0000, 5'd4, 2'd0},   // R6 trap return
        {3'd3, 32'h0000_0000, 5'd4, 2'd3},   // R5 illegal return
        {3'd0, 32'h0000_0000, 5'd4, 2'd0}    // R10 idle
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    // Raise the strobe(s) for one cycle starting at a falling edge.
    task automatic pulse(input int op, input logic [31:0] data);
        srw_data    = data;
        mask_data   = data[NW-1:0];
        save_req    = (op == 1);
        restore_req = (op == 2);
        rett_req    = (op == 3);
        srw_req     = (op == 4);
        mask_we     = (op == 5);
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0; rett_req = 1'b0;
        srw_req = 1'b0; mask_we = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        // R1: reset state at start
        check("R1 cwp", {27'd0, cwp}, 32'd0);
        check("R1 sr", sr_rdata, 32'h3C00_0080);
        check("R1 trap", {31'd0, trap_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < 13; i++) begin
            pulse(int'(VEC[i][41:39]), VEC[i][38:7]);
            check($sformatf("vec%0d cwp R2/R3/R4/R6", i), {27'd0, cwp}, {27'd0, VEC[i][6:2]});
            check($sformatf("vec%0d cause R4/R5/R7/R10", i),
                  {29'd0, trap_valid, trap_cause},
                  {29'd0, (VEC[i][1:0] != 2'd0), VEC[i][1:0]});
        end

        // R9 R8 R6: packed word after legal write then trap return
        check("R9 packed", sr_rdata, 32'h3CA0_15E4);

        // R7: illegal write leaves the whole word intact
        snap = sr_rdata;
        pulse(4, 32'h0000_0F1F);
        check("R7 cause", {30'd0, trap_cause}, 32'd3);
        check("R7 nochange", sr_rdata, snap);

        // R8: status write to window 6, traps disabled, supervisor on
        pulse(4, 32'h0000_0086);
        check("R8 sr", sr_rdata, 32'h3C00_0086);

        // R6: trap return into masked window 7 -> underflow, ET still set
        pulse(3, 32'h0);
        check("R6 cause", {30'd0, trap_cause}, 32'd2);
        check("R6 cwp", {27'd0, cwp}, 32'd6);
        check("R6 et/s", {30'd0, traps_en, sup}, 32'd3);
        // R10: pulse lasts one cycle
        @(negedge clk);
        check("R10 pulse width", {31'd0, trap_valid}, 32'd0);

        // R11: save and restore together -> save wins
        pulse(5, 32'h0);
        save_req = 1'b1; restore_req = 1'b1;
        @(negedge clk);
        save_req = 1'b0; restore_req = 1'b0;
        check("R11 save wins", {25'd0, trap_valid, cwp, trap_cause}, {25'd0, 1'b0, 5'd5, 2'd0});

        // R11: trap return beats status write; write ignored
        srw_data = 32'h0000_0905; rett_req = 1'b1; srw_req = 1'b1;
        @(negedge clk);
        rett_req = 1'b0; srw_req = 1'b0;
        check("R11 rett wins", {30'd0, trap_cause}, 32'd3);
        check("R11 write ignored", {23'd0, pil, cwp}, {23'd0, 4'd0, 5'd5});

        // R1: reset mid-run clears state and mask
        pulse(5, 32'h0000_0002);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset sr", sr_rdata, 32'h3C00_0080);
        check("R1 reset trap", {29'd0, trap_valid, trap_cause}, 32'd0);
        pulse(2, 32'h0);
        check("R1 mask cleared", {25'd0, trap_valid, cwp, trap_cause}, {25'd0, 1'b0, 5'd1, 2'd0});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule